// File: doc/BRIEF.md
# MDIO PHY Discovery and Link Monitor

This block sweeps every management address in the background. It asks an external MDIO frame engine to read the basic status register of each address in turn. From each answer it keeps two 32-bit maps. The presence map shows which addresses had a PHY respond on the latest poll. The link map shows which of those PHYs report link up. Software can read both maps at any time without starting a management transaction of its own.

Two watch slots let software pick PHYs whose link state needs close attention. Each slot holds a PHY address and an enable bit. When the sweep reaches a watched address, the block compares the link bit with the value it recorded on the previous poll. Any difference latches a sticky event for that slot. The events are cleared by writing a one. A per-slot enable selects which events drive the registered interrupt line.

The frame engine connects through a request/acknowledge pair and a response strobe. The response carries the read data and a flag that says whether any PHY answered. The block keeps at most one transaction outstanding.

Top module: `mdio_link_watch`

## Requirements
- R1: Request addresses step upward by one per completed poll, starting at 0 after reset and wrapping from 31 back to 0.
- R2: Every request targets status register number 1.
- R3: `req_valid` stays high with a stable address until `req_ack` is seen. It stays low from the acknowledge until the matching `rsp_valid`.
- R4: After a response, bit `a` of `alive_map` (where `a` is the polled address) equals `rsp_present`.
- R5: After a response, bit `a` of `link_map` equals `rsp_present` AND `rsp_data[2]`. An absent PHY always reads as link down.
- R6: When an enabled slot's PHY is polled and its link bit differs from the value recorded on the previous poll of that slot, `evt[i]` becomes 1 and stays 1 until it is cleared.
- R7: The first poll of a slot after reset, after its enable rises, or after its address changes only records a reference value and sets no event.
- R8: A one on `evt_clear[i]` clears `evt[i]`. If a new event for that slot arrives in the same cycle, the event is kept.
- R9: `irq` is registered and equals the OR over `evt & irq_en` from the previous cycle.
- R10: While reset is held, `alive_map`, `link_map`, `evt` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | output | 1 | Read request to the frame engine |
| req_addr | output | 5 | PHY address of the request |
| req_reg | output | 5 | Register number of the request (always 1) |
| req_ack | input | 1 | Frame engine has accepted the request |
| rsp_valid | input | 1 | Response strobe, one cycle |
| rsp_present | input | 1 | A PHY drove the turnaround |
| rsp_data | input | 16 | Register read data |
| slot_addr | input | 2x5 | PHY address of each watch slot |
| slot_en | input | 2 | Enable of each watch slot |
| evt_clear | input | 2 | Write-one-to-clear pulse per slot event |
| irq_en | input | 2 | Interrupt enable per slot event |
| alive_map | output | 32 | Presence bit per address |
| link_map | output | 32 | Link-up bit per address |
| evt | output | 2 | Sticky link-change event per slot |
| irq | output | 1 | Interrupt request |

## Verification
A link-change event on a slot can land in the same cycle that software writes the clear for that slot. The bench provokes this by pulsing `evt_clear` in the exact cycle it drives `rsp_valid` for a watched address whose link bit has flipped again. It judges the result by requiring the event to survive. A second clear with no competing change must then drop it. A separate case sets an event while its interrupt enable is low, which shows that the event and `irq` are independent.

// File: rtl/mdio_watch_pkg.sv
package mdio_watch_pkg;
  typedef enum logic {ST_REQ, ST_WAIT} poll_st_t;
endpackage

// File: rtl/mdio_poll_seq.sv
module mdio_poll_seq
  import mdio_watch_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int REG_W      = 5,
  parameter int DATA_W     = 16,
  parameter int STATUS_REG = 1,
  parameter int LINK_BIT   = 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [REG_W-1:0]  req_reg,
  input  logic              req_ack,
  input  logic              rsp_valid,
  input  logic              rsp_present,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              done,
  output logic              res_present,
  output logic              res_link
);
  poll_st_t          state;
  logic [ADDR_W-1:0] cur_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_REQ;
      cur_addr <= '0;
    end else begin
      case (state)
        ST_REQ:  if (req_ack) state <= ST_WAIT;
        ST_WAIT: if (rsp_valid) begin
          state    <= ST_REQ;
          cur_addr <= cur_addr + 1'b1;
        end
        default: state <= ST_REQ;
      endcase
    end
  end

  assign req_valid   = (state == ST_REQ);
  assign req_addr    = cur_addr;
  assign req_reg     = REG_W'(STATUS_REG);
  assign done        = (state == ST_WAIT) && rsp_valid;
  assign res_present = rsp_present;
  assign res_link    = rsp_present & rsp_data[LINK_BIT];
endmodule

// File: rtl/mdio_phy_maps.sv
module mdio_phy_maps #(
  parameter int NUM_ADDR = 32,
  parameter int ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                done,
  input  logic [ADDR_W-1:0]   res_addr,
  input  logic                res_present,
  input  logic                res_link,
  output logic [NUM_ADDR-1:0] alive_map,
  output logic [NUM_ADDR-1:0] link_map
);
  always_ff @(posedge clk) begin
    if (rst) begin
      alive_map <= '0;
      link_map  <= '0;
    end else if (done) begin
      alive_map[res_addr] <= res_present;
      link_map[res_addr]  <= res_link;
    end
  end
endmodule

// File: rtl/mdio_link_slot.sv
module mdio_link_slot #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] slot_addr,
  input  logic              slot_en,
  input  logic              clear,
  input  logic              done,
  input  logic [ADDR_W-1:0] res_addr,
  input  logic              res_link,
  output logic              evt
);
  logic              ref_valid;
  logic              ref_link;
  logic [ADDR_W-1:0] seen_addr;
  logic              hit;
  logic              change;

  assign hit    = done && slot_en && ref_valid && (seen_addr == slot_addr) && (res_addr == slot_addr);
  assign change = hit && (res_link != ref_link);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_valid <= 1'b0;
      ref_link  <= 1'b0;
      seen_addr <= '0;
      evt       <= 1'b0;
    end else begin
      seen_addr <= slot_addr;
      if (!slot_en || seen_addr != slot_addr) begin
        ref_valid <= 1'b0;
      end else if (done && res_addr == slot_addr) begin
        ref_valid <= 1'b1;
        ref_link  <= res_link;
      end
      if (change)     evt <= 1'b1;
      else if (clear) evt <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_link_watch.sv
module mdio_link_watch #(
  parameter int NUM_ADDR   = 32,
  parameter int ADDR_W     = 5,
  parameter int REG_W      = 5,
  parameter int DATA_W     = 16,
  parameter int NUM_SLOTS  = 2,
  parameter int STATUS_REG = 1,
  parameter int LINK_BIT   = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  output logic                              req_valid,
  output logic [ADDR_W-1:0]                 req_addr,
  output logic [REG_W-1:0]                  req_reg,
  input  logic                              req_ack,
  input  logic                              rsp_valid,
  input  logic                              rsp_present,
  input  logic [DATA_W-1:0]                 rsp_data,
  input  logic [NUM_SLOTS-1:0][ADDR_W-1:0]  slot_addr,
  input  logic [NUM_SLOTS-1:0]              slot_en,
  input  logic [NUM_SLOTS-1:0]              evt_clear,
  input  logic [NUM_SLOTS-1:0]              irq_en,
  output logic [NUM_ADDR-1:0]               alive_map,
  output logic [NUM_ADDR-1:0]               link_map,
  output logic [NUM_SLOTS-1:0]              evt,
  output logic                              irq
);
  logic done, res_present, res_link;

  mdio_poll_seq #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .DATA_W(DATA_W),
    .STATUS_REG(STATUS_REG), .LINK_BIT(LINK_BIT)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_reg(req_reg),
    .req_ack(req_ack), .rsp_valid(rsp_valid), .rsp_present(rsp_present),
    .rsp_data(rsp_data), .done(done), .res_present(res_present), .res_link(res_link)
  );

  mdio_phy_maps #(.NUM_ADDR(NUM_ADDR), .ADDR_W(ADDR_W)) u_maps (
    .clk(clk), .rst(rst), .done(done), .res_addr(req_addr),
    .res_present(res_present), .res_link(res_link),
    .alive_map(alive_map), .link_map(link_map)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    mdio_link_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk(clk), .rst(rst), .slot_addr(slot_addr[i]), .slot_en(slot_en[i]),
      .clear(evt_clear[i]), .done(done), .res_addr(req_addr),
      .res_link(res_link), .evt(evt[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(evt & irq_en);
  end
endmodule

// File: rtl/mdio_link_watch_chk.sv
module mdio_link_watch_chk #(
  parameter int NUM_ADDR  = 32,
  parameter int ADDR_W    = 5,
  parameter int REG_W     = 5,
  parameter int NUM_SLOTS = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic [ADDR_W-1:0]    req_addr,
  input logic [REG_W-1:0]     req_reg,
  input logic                 req_ack,
  input logic                 rsp_valid,
  input logic                 rsp_present,
  input logic [NUM_ADDR-1:0]  link_map,
  input logic [NUM_SLOTS-1:0] evt,
  input logic [NUM_SLOTS-1:0] evt_clear,
  input logic [NUM_SLOTS-1:0] irq_en,
  input logic                 irq
);
  logic pending;
  always_ff @(posedge clk) begin
    if (rst)                       pending <= 1'b0;
    else if (req_valid && req_ack) pending <= 1'b1;
    else if (rsp_valid)            pending <= 1'b0;
  end

  a_r3_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    pending |-> !req_valid);
  a_r3_hold_request: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ack) |=> (req_valid && $stable(req_addr)));
  a_r2_status_reg: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_reg == REG_W'(1)));
  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    (pending && rsp_valid) |=> (req_addr == ADDR_W'($past(req_addr) + 1'b1)));
  a_r5_absent_down: assert property (@(posedge clk) disable iff (rst)
    (pending && rsp_valid && !rsp_present) |=> !link_map[$past(req_addr)]);
  a_r8_sticky0: assert property (@(posedge clk) disable iff (rst)
    (evt[0] && !evt_clear[0]) |=> evt[0]);
  a_r8_sticky1: assert property (@(posedge clk) disable iff (rst)
    (evt[1] && !evt_clear[1]) |=> evt[1]);
  a_r9_irq: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(evt & irq_en))));
endmodule

bind mdio_link_watch mdio_link_watch_chk #(
  .NUM_ADDR(NUM_ADDR), .ADDR_W(ADDR_W), .REG_W(REG_W), .NUM_SLOTS(NUM_SLOTS)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .req_reg(req_reg), .req_ack(req_ack), .rsp_valid(rsp_valid),
  .rsp_present(rsp_present), .link_map(link_map), .evt(evt),
  .evt_clear(evt_clear), .irq_en(irq_en), .irq(irq)
);

// File: tb/tb_mdio_link_watch.sv
module tb_mdio_link_watch;
  logic clk = 0;
  logic rst = 1;
  logic req_valid, req_ack = 0, rsp_valid = 0, rsp_present = 0;
  logic [4:0] req_addr, req_reg;
  logic [15:0] rsp_data = '0;
  logic [1:0][4:0] slot_addr;
  logic [1:0] slot_en = '0, irq_en = '0, clr_main = '0, clr_coll = '0, evt_clear, evt;
  logic [31:0] alive_map, link_map;
  logic irq;

  int total = 0, bad = 0;
  bit phy_present[32];
  bit phy_link[32];
  int collide_addr = -1;
  int exp_next = 0;

  typedef struct { int a; bit p; bit l; } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;
  assign evt_clear = clr_main | clr_coll;

  mdio_link_watch dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_reg(req_reg), .req_ack(req_ack), .rsp_valid(rsp_valid),
    .rsp_present(rsp_present), .rsp_data(rsp_data), .slot_addr(slot_addr),
    .slot_en(slot_en), .evt_clear(evt_clear), .irq_en(irq_en),
    .alive_map(alive_map), .link_map(link_map), .evt(evt), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // responder: plays the frame engine and pushes expected map entries
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && req_valid) begin
        automatic int a = req_addr;
        check("R1 address order", req_addr, exp_next);
        check("R2 register number", req_reg, 1);
        req_ack = 1;
        @(negedge clk);
        req_ack = 0;
        check("R3 no request while pending", req_valid, 0);
        @(negedge clk);
        check("R3 no request while pending", req_valid, 0);
        rsp_valid   = 1;
        rsp_present = phy_present[a];
        rsp_data    = phy_present[a] ? (phy_link[a] ? 16'h7869 | 16'h0004 : 16'h7869 & ~16'h0004) : 16'hFFFF;
        if (a == collide_addr) begin
          clr_coll = 2'b01;
          collide_addr = -1;
        end
        @(negedge clk);
        rsp_valid = 0;
        clr_coll  = '0;
        sb_q.push_back('{a, phy_present[a], phy_link[a]});
        exp_next = (exp_next + 1) % 32;
      end
    end
  end

  // monitor: compares maps with queued expectations
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        automatic item_t it = sb_q.pop_front();
        check("R4 alive bit", alive_map[it.a], it.p);
        check("R5 link bit", link_map[it.a], it.p & it.l);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic wait_sweeps(input int n);
    repeat (n * 160) @(negedge clk);
  endtask

  initial begin
    foreach (phy_present[i]) begin phy_present[i] = 0; phy_link[i] = 0; end
    phy_present[3] = 1;  phy_link[3] = 0;
    phy_present[7] = 1;  phy_link[7] = 0;
    phy_present[9] = 1;  phy_link[9] = 1;
    phy_present[20] = 1; phy_link[20] = 1;
    phy_present[31] = 1; phy_link[31] = 0;
    phy_link[12] = 1; // absent: link must read 0 (R5)
    slot_addr[0] = 5'd3; slot_addr[1] = 5'd7;
    slot_en = 2'b11; irq_en = 2'b01;
    repeat (4) @(negedge clk);
    check("R10 alive reset", alive_map, 0);
    check("R10 link reset", link_map, 0);
    check("R10 evt reset", evt, 0);
    check("R10 irq reset", irq, 0);
    rst = 0;

    wait_sweeps(2);
    check("R7 first poll no event", evt, 0);
    check("R9 irq idle", irq, 0);
    check("R5 absent link map", link_map[12], 0);

    phy_link[3] = 1;
    wait_sweeps(2);
    check("R6 slot0 link change", evt, 2'b01);
    check("R9 irq enabled event", irq, 1);

    clr_main = 2'b01; @(negedge clk); clr_main = 0;
    check("R8 clear event", evt, 0);
    @(negedge clk);
    check("R9 irq drops after clear", irq, 0);

    phy_link[7] = 1;
    wait_sweeps(2);
    check("R6 slot1 link change", evt, 2'b10);
    check("R9 masked event no irq", irq, 0);
    clr_main = 2'b10; @(negedge clk); clr_main = 0;
    check("R8 clear slot1", evt, 0);

    slot_addr[0] = 5'd31; // link 0 vs previous reference 1
    wait_sweeps(2);
    check("R7 address change no event", evt, 0);

    phy_link[31] = 1;
    wait_sweeps(2);
    check("R6 slot0 new address change", evt, 2'b01);
    phy_link[31] = 0;
    collide_addr = 31;
    wait_sweeps(2);
    check("R8 set wins over clear", evt, 2'b01);
    clr_main = 2'b01; @(negedge clk); clr_main = 0;
    check("R8 plain clear", evt, 0);

    phy_present[9] = 0;
    slot_en[1] = 0;
    phy_link[7] = 0;
    wait_sweeps(2);
    check("R5 lost phy link down", link_map[9], 0);
    check("R4 lost phy absent", alive_map[9], 0);
    slot_en[1] = 1;
    phy_link[7] = 1;
    wait_sweeps(2);
    check("R7 re-enable no event", evt, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule